// File: doc/BRIEF.md
# Register Vector-Length Expansion Sequencer

This block sits between an instruction decoder and the execution lanes of a core with a 32-entry register file. It keeps a small configuration table with one entry per register: a vector length and a 2-bit data-width code. A register whose length is above 1 stands for itself and the registers numbered after it. When the decoder issues an ordinary three-operand instruction, the sequencer reads the entries of `rd`, `rs1` and `rs2`. It then turns the instruction into a series of element micro-operations with renumbered registers. Whether each operand is scalar or vector comes from the table, not from the opcode. A scalar source is repeated for every element, which gives the scalar-vector forms without any extra opcodes.

A per-element predicate mask travels with each instruction. An element whose bit is clear produces nothing, so its destination register is never written. Both the issue side and the micro-op side use valid/ready. An instruction is taken when `in_valid` and `in_ready` are high at the same clock edge. From that edge, `in_ready` stays low until every element has been either accepted downstream or dropped. A micro-op is handed over when `uop_valid` and `uop_ready` are high at the same edge. While `uop_ready` is low, the offered micro-op is held unchanged. The table entries are copied when an instruction is accepted, so table writes made during expansion apply only to later instructions.

Top module: `vlx_seq`

## Requirements
- R1: After reset, every table entry holds length 1 and width code 0, `in_ready` is 1 and `uop_valid` is 0. An instruction whose registers are all at their defaults gives exactly one micro-op, with element 0 and unchanged register numbers.
- R2: When `cfg_we` is high at a clock edge, the entry `cfg_idx` takes `cfg_vl` and `cfg_dw`. A written length of 0 is stored as 1.
- R3: The element count is the largest length among `rd`, `rs1` and `rs2`. For element e, an operand whose length is above 1 is renumbered to its register plus e. An operand of length 1 keeps its register number for every element.
- R4: Micro-ops leave in increasing element order, and `uop_elem` carries the element number e.
- R5: An element whose predicate bit (bit e of `in_pred`) is 0 produces no micro-op and no error.
- R6: An enabled element for which any renumbered index would exceed 31 produces no micro-op. Instead, `oob_err` is high for one cycle for that element.
- R7: `in_ready` is low from the accepting edge until all elements have been accepted or dropped. It never rises while a micro-op is being offered or an error is flagged.
- R8: While `uop_valid` is high and `uop_ready` is low, the next cycle still offers the same micro-op with the same fields.
- R9: `uop_dw` equals the width code held for `rd` when the instruction was accepted.
- R10: Different registers hold different lengths at the same time. Back-to-back instructions that use them (for example r0 with length 16 and r7 with length 5) expand correctly without rewriting the table in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 5 | Register whose entry is written |
| cfg_vl | input | VLW (6) | Vector length to store |
| cfg_dw | input | 2 | Data-width code to store |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle and able to accept |
| in_rd | input | 5 | Destination register |
| in_rs1 | input | 5 | First source register |
| in_rs2 | input | 5 | Second source register |
| in_pred | input | 2**VLW (64) | Per-element enable mask |
| uop_valid | output | 1 | Micro-op offered |
| uop_ready | input | 1 | Downstream accepts micro-op |
| uop_rd | output | 5 | Renumbered destination |
| uop_rs1 | output | 5 | Renumbered first source |
| uop_rs2 | output | 5 | Renumbered second source |
| uop_elem | output | VLW (6) | Element number |
| uop_dw | output | 2 | Data-width code of the destination |
| oob_err | output | 1 | Enabled element dropped for exceeding the register file |

## Verification
The bench builds the block with its defaults: 32 registers and a 6-bit length field. Lengths therefore reach 63, and the predicate mask is 64 bits wide. This makes it easy to push renumbering past register 31 from both low and high base registers, and to mix short and long operands in one instruction. Random downstream back-pressure exercises the hold rule on every micro-op.

// File: rtl/vlx_pkg.sv
package vlx_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  localparam int unsigned NUM_OPS = 3;
  localparam int unsigned OP_RD   = 0;
  localparam int unsigned OP_RS1  = 1;
  localparam int unsigned OP_RS2  = 2;
endpackage

// File: rtl/vlx_cfg_table.sv
module vlx_cfg_table #(
  parameter int unsigned NREG = 32,
  parameter int unsigned VLW  = 6,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [IW-1:0]  widx,
  input  logic [VLW-1:0] wvl,
  input  logic [1:0]     wdw,
  input  logic [IW-1:0]  ridx [vlx_pkg::NUM_OPS],
  output logic [VLW-1:0] rvl  [vlx_pkg::NUM_OPS],
  output logic [1:0]     rdw  [vlx_pkg::NUM_OPS]
);
  logic [VLW-1:0] vl_q [NREG];
  logic [1:0]     dw_q [NREG];
  logic [VLW-1:0] wvl_fix;

  assign wvl_fix = (wvl == '0) ? VLW'(1) : wvl;

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vl_q[g] <= VLW'(1);
        dw_q[g] <= 2'd0;
      end else if (we && widx == IW'(g)) begin
        vl_q[g] <= wvl_fix;
        dw_q[g] <= wdw;
      end
    end
  end

  for (genvar p = 0; p < vlx_pkg::NUM_OPS; p++) begin : g_rd
    assign rvl[p] = vl_q[ridx[p]];
    assign rdw[p] = dw_q[ridx[p]];
  end
endmodule

// File: rtl/vlx_elem_map.sv
module vlx_elem_map #(
  parameter int unsigned NREG = 32,
  parameter int unsigned VLW  = 6,
  localparam int unsigned IW  = $clog2(NREG),
  localparam int unsigned SW  = IW + VLW + 1
) (
  input  logic [IW-1:0]  base,
  input  logic           is_vec,
  input  logic [VLW-1:0] elem,
  output logic [IW-1:0]  idx,
  output logic           oob
);
  logic [SW-1:0] sum;

  assign sum = SW'(base) + SW'(elem);
  assign oob = is_vec && (sum > SW'(NREG - 1));
  assign idx = is_vec ? sum[IW-1:0] : base;
endmodule

// File: rtl/vlx_seq.sv
module vlx_seq #(
  parameter int unsigned NREG = 32,
  parameter int unsigned VLW  = 6,
  localparam int unsigned IW  = $clog2(NREG),
  localparam int unsigned PW  = 1 << VLW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_idx,
  input  logic [VLW-1:0] cfg_vl,
  input  logic [1:0]     cfg_dw,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [IW-1:0]  in_rd,
  input  logic [IW-1:0]  in_rs1,
  input  logic [IW-1:0]  in_rs2,
  input  logic [PW-1:0]  in_pred,
  output logic           uop_valid,
  input  logic           uop_ready,
  output logic [IW-1:0]  uop_rd,
  output logic [IW-1:0]  uop_rs1,
  output logic [IW-1:0]  uop_rs2,
  output logic [VLW-1:0] uop_elem,
  output logic [1:0]     uop_dw,
  output logic           oob_err
);
  import vlx_pkg::*;

  seq_state_e     state_q;
  logic [IW-1:0]  base_q  [NUM_OPS];
  logic           vec_q   [NUM_OPS];
  logic [VLW-1:0] cnt_q;
  logic [VLW-1:0] elem_q;
  logic [PW-1:0]  pred_q;
  logic [1:0]     dw_q;

  logic [IW-1:0]  in_regs [NUM_OPS];
  logic [VLW-1:0] tbl_vl  [NUM_OPS];
  logic [1:0]     tbl_dw  [NUM_OPS];
  logic [IW-1:0]  map_idx [NUM_OPS];
  logic           map_oob [NUM_OPS];
  logic [VLW-1:0] max_vl;
  logic           run, act, any_oob, adv, last, take;

  assign in_regs[OP_RD]  = in_rd;
  assign in_regs[OP_RS1] = in_rs1;
  assign in_regs[OP_RS2] = in_rs2;

  vlx_cfg_table #(.NREG(NREG), .VLW(VLW)) u_table (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (cfg_we),
    .widx (cfg_idx),
    .wvl  (cfg_vl),
    .wdw  (cfg_dw),
    .ridx (in_regs),
    .rvl  (tbl_vl),
    .rdw  (tbl_dw)
  );

  for (genvar p = 0; p < NUM_OPS; p++) begin : g_map
    vlx_elem_map #(.NREG(NREG), .VLW(VLW)) u_map (
      .base  (base_q[p]),
      .is_vec(vec_q[p]),
      .elem  (elem_q),
      .idx   (map_idx[p]),
      .oob   (map_oob[p])
    );
  end

  always_comb begin
    max_vl = tbl_vl[0];
    for (int p = 1; p < NUM_OPS; p++)
      if (tbl_vl[p] > max_vl) max_vl = tbl_vl[p];
  end

  always_comb begin
    any_oob = 1'b0;
    for (int p = 0; p < NUM_OPS; p++) any_oob = any_oob | map_oob[p];
  end

  assign run      = (state_q == SEQ_RUN);
  assign act      = pred_q[elem_q];
  assign in_ready = !run;
  assign take     = in_valid && in_ready;
  assign adv      = run && (!act || any_oob || uop_ready);
  assign last     = (elem_q == cnt_q - VLW'(1));

  assign uop_valid = run && act && !any_oob;
  assign oob_err   = run && act && any_oob;
  assign uop_rd    = map_idx[OP_RD];
  assign uop_rs1   = map_idx[OP_RS1];
  assign uop_rs2   = map_idx[OP_RS2];
  assign uop_elem  = elem_q;
  assign uop_dw    = dw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= VLW'(1);
      elem_q  <= '0;
      pred_q  <= '0;
      dw_q    <= 2'd0;
      for (int p = 0; p < NUM_OPS; p++) begin
        base_q[p] <= '0;
        vec_q[p]  <= 1'b0;
      end
    end else if (take) begin
      state_q <= SEQ_RUN;
      cnt_q   <= max_vl;
      elem_q  <= '0;
      pred_q  <= in_pred;
      dw_q    <= tbl_dw[OP_RD];
      for (int p = 0; p < NUM_OPS; p++) begin
        base_q[p] <= in_regs[p];
        vec_q[p]  <= (tbl_vl[p] > VLW'(1));
      end
    end else if (adv) begin
      if (last) state_q <= SEQ_IDLE;
      else      elem_q  <= elem_q + VLW'(1);
    end
  end
endmodule

// File: rtl/vlx_seq_chk.sv
module vlx_seq_chk #(
  parameter int unsigned NREG = 32,
  parameter int unsigned VLW  = 6,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic           uop_valid,
  input logic           uop_ready,
  input logic [IW-1:0]  uop_rd,
  input logic [IW-1:0]  uop_rs1,
  input logic [IW-1:0]  uop_rs2,
  input logic [VLW-1:0] uop_elem,
  input logic [1:0]     uop_dw,
  input logic           oob_err
);
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_ready |=> uop_valid && $stable(uop_rd) && $stable(uop_rs1)
      && $stable(uop_rs2) && $stable(uop_elem) && $stable(uop_dw));

  a_r7_busy_while_offering: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> !in_ready);

  a_r7_busy_while_error: assert property (@(posedge clk) disable iff (!rst_n)
    oob_err |-> !in_ready);

  a_r6_error_not_issued: assert property (@(posedge clk) disable iff (!rst_n)
    oob_err |-> !uop_valid);

  a_r4_rising_elements: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_ready |=> !uop_valid || (uop_elem > $past(uop_elem)));
endmodule

bind vlx_seq vlx_seq_chk #(.NREG(NREG), .VLW(VLW)) u_vlx_seq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .uop_valid(uop_valid),
  .uop_ready(uop_ready),
  .uop_rd   (uop_rd),
  .uop_rs1  (uop_rs1),
  .uop_rs2  (uop_rs2),
  .uop_elem (uop_elem),
  .uop_dw   (uop_dw),
  .oob_err  (oob_err)
);

// File: tb/vlx_seq_bench.sv
module vlx_seq_bench;
  localparam int NREG = 32;
  localparam int VLW  = 6;
  localparam int PW   = 1 << VLW;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_idx = '0;
  logic [VLW-1:0] cfg_vl = '0;
  logic [1:0] cfg_dw = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [4:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [PW-1:0] in_pred = '0;
  logic uop_valid;
  logic uop_ready = 1'b0;
  logic [4:0] uop_rd, uop_rs1, uop_rs2;
  logic [VLW-1:0] uop_elem;
  logic [1:0] uop_dw;
  logic oob_err;

  int tests = 0;
  int fails = 0;
  int m_vl [NREG];
  int m_dw [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  vlx_seq #(.NREG(NREG), .VLW(VLW)) u_vlx_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vl(cfg_vl), .cfg_dw(cfg_dw),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_pred(in_pred),
    .uop_valid(uop_valid), .uop_ready(uop_ready),
    .uop_rd(uop_rd), .uop_rs1(uop_rs1), .uop_rs2(uop_rs2),
    .uop_elem(uop_elem), .uop_dw(uop_dw), .oob_err(oob_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input int idx, input int vl, input int dw);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_vl = VLW'(vl); cfg_dw = 2'(dw);
    @(negedge clk);
    cfg_we = 1'b0;
    m_vl[idx] = (vl == 0) ? 1 : vl;
    m_dw[idx] = dw;
  endtask

  function automatic int max3(input int a, input int b, input int c);
    int m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  function automatic int renum(input int base, input int e);
    return (m_vl[base] > 1) ? base + e : base;
  endfunction

  task automatic run_instr(input int rd, input int rs1, input int rs2,
                           input logic [PW-1:0] pred, input string req, input int rdy_pct);
    int exp_rd [PW]; int exp_r1 [PW]; int exp_r2 [PW]; int exp_el [PW];
    int nexp = 0; int nerr = 0; int got = 0; int errs = 0;
    int cnt = max3(m_vl[rd], m_vl[rs1], m_vl[rs2]);
    int dwx = m_dw[rd];
    bit held = 0; int h_rd = 0; int h_el = 0; int guard = 0;
    for (int e = 0; e < cnt; e++) begin
      if (pred[e]) begin
        int a = renum(rd, e); int b = renum(rs1, e); int c = renum(rs2, e);
        if (a > NREG-1 || b > NREG-1 || c > NREG-1) nerr++;
        else begin
          exp_rd[nexp] = a; exp_r1[nexp] = b; exp_r2[nexp] = c; exp_el[nexp] = e;
          nexp++;
        end
      end
    end
    @(negedge clk);
    check(in_ready === 1'b1, "R7", "ready when idle", int'(in_ready), 1);
    in_valid = 1'b1; in_rd = 5'(rd); in_rs1 = 5'(rs1); in_rs2 = 5'(rs2); in_pred = pred;
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready === 1'b0, "R7", "busy after accept", int'(in_ready), 0);
    while (!in_ready && guard < 2000) begin
      bit r;
      guard++;
      if (held) begin
        check(uop_valid && uop_rd == 5'(h_rd) && uop_elem == VLW'(h_el), "R8",
              "stalled uop held", int'(uop_elem), h_el);
        held = 0;
      end
      if (oob_err) errs++;
      r = (($urandom % 100) < rdy_pct);
      uop_ready = r;
      if (uop_valid && r) begin
        if (got < nexp)
          check(uop_rd == 5'(exp_rd[got]) && uop_rs1 == 5'(exp_r1[got]) &&
                uop_rs2 == 5'(exp_r2[got]) && uop_elem == VLW'(exp_el[got]),
                req, "uop regs/elem", {uop_rd, uop_rs1, uop_rs2, 2'b0, uop_elem},
                {exp_rd[got][4:0], exp_r1[got][4:0], exp_r2[got][4:0], 2'b0, exp_el[got][5:0]});
        check(uop_dw == 2'(dwx), "R9", "uop width code", int'(uop_dw), dwx);
        got++;
      end else if (uop_valid) begin
        held = 1; h_rd = int'(uop_rd); h_el = int'(uop_elem);
      end
      @(negedge clk);
    end
    uop_ready = 1'b0;
    check(got == nexp, req, "uop count", got, nexp);
    check(errs == nerr, "R6", "overflow error count", errs, nerr);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NREG; i++) begin m_vl[i] = 1; m_dw[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    check(uop_valid === 1'b0, "R1", "uop_valid after reset", int'(uop_valid), 0);
    check(oob_err === 1'b0, "R1", "oob_err after reset", int'(oob_err), 0);
    // R1: all defaults scalar, one uop
    run_instr(3, 9, 20, '1, "R1", 100);
    // R2: length 0 stored as 1
    write_cfg(5, 0, 2);
    run_instr(5, 6, 7, '1, "R2", 100);
    // R3: scalar broadcast with vector destination
    write_cfg(10, 4, 1);
    run_instr(10, 2, 2, '1, "R3", 100);
    // R10: r0 length 16, r7 length 5, back to back
    write_cfg(0, 16, 3);
    write_cfg(7, 5, 1);
    run_instr(0, 0, 0, '1, "R10", 70);
    run_instr(7, 7, 1, '1, "R10", 70);
    // R5: cleared predicate bits skip elements
    run_instr(0, 0, 30, 64'hA5A5, "R5", 100);
    run_instr(7, 7, 7, 64'h0, "R5", 100);
    // R6: overflow at the top of the file
    write_cfg(30, 4, 2);
    run_instr(30, 30, 4, '1, "R6", 100);
    write_cfg(26, 63, 0);
    run_instr(26, 1, 2, 64'hFFFF_0000_0000_00FF, "R6", 50);
    // R4/R8: random configuration and back-pressure
    for (int t = 0; t < 60; t++) begin
      int k = $urandom % 4;
      int idx = $urandom % NREG;
      int vl = (k == 0) ? ($urandom % 64) : ($urandom % 8);
      write_cfg(idx, vl, $urandom % 4);
      run_instr($urandom % NREG, $urandom % NREG, $urandom % NREG,
                {$urandom, $urandom}, "R4", 40 + ($urandom % 60));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule